// File: doc/BRIEF.md
# Single-Bit Manipulation and Test Unit

This block is a purely combinational datapath slice that acts on one chosen bit of a 16-bit operand. The caller supplies the operand, a 4-bit position taken from an immediate field or from the low bits of a second register, an operation code, and the present carry (C) and zero (Z) flags. In the same evaluation the unit returns the rewritten word with its write-enable, and the new C and Z values, each with its own update enable.

The unit covers setting, clearing and flipping a bit, copying a bit into C or (inverted) into Z, capturing a bit into C or Z while forcing it to 1, and storing the present C or Z into a bit. It has no clock and holds no state. The enclosing sequencer latches the word and the flags on their enables, and it handles any skip or branch decision based on a tested bit.

Top module: `bitmanip_unit`

## Requirements
- R1: Operation codes on `op_i` are 0 set, 1 clear, 2 flip, 3 test-to-C, 4 test-to-Z, 5 test-then-set into C, 6 test-then-set into Z, 7 store C into bit, 8 store Z into bit. Set (0), clear (1) and flip (2) change only the indexed bit of `opnd_i` on `word_o`, assert `word_we_o`, and assert neither `c_we_o` nor `z_we_o`.
- R2: With `idx_from_reg_i` = 0 the position is `imm_idx_i`. With `idx_from_reg_i` = 1 it is `reg_idx_i[3:0]`, and bits 15:4 of `reg_idx_i` have no effect.
- R3: Test-to-C (3) drives `c_o` with the indexed bit and asserts `c_we_o`. It leaves `word_we_o` and `z_we_o` low.
- R4: Test-to-Z (4) drives `z_o` with the inverse of the indexed bit and asserts `z_we_o`. It leaves `word_we_o` and `c_we_o` low.
- R5: Test-then-set into C (5) drives `c_o` with the bit's old value and asserts `c_we_o`. It outputs the operand with the indexed bit forced to 1 and asserts `word_we_o`. `z_we_o` stays low.
- R6: Test-then-set into Z (6) drives `z_o` with the inverse of the bit's old value and asserts `z_we_o`. It outputs the operand with the indexed bit forced to 1 and asserts `word_we_o`. `c_we_o` stays low.
- R7: Store C (7) writes `c_i` into the indexed bit, leaves every other bit unchanged, and asserts `word_we_o` with no flag enables.
- R8: Store Z (8) writes `z_i` into the indexed bit, leaves every other bit unchanged, and asserts `word_we_o` with no flag enables.
- R9: Codes 9 to 15 assert no enable and pass `opnd_i` to `word_o` unchanged.
- R10: When a flag's enable is low, its output equals its input (`c_o` = `c_i`, `z_o` = `z_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 16 | Operand word |
| imm_idx_i | input | 4 | Bit position from the immediate field |
| reg_idx_i | input | 16 | Register whose low 4 bits may give the position |
| idx_from_reg_i | input | 1 | 1 selects the register as the position source |
| op_i | input | 4 | Operation code |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| word_o | output | 16 | Resulting word |
| word_we_o | output | 1 | Result word should be written back |
| c_o | output | 1 | New carry value |
| c_we_o | output | 1 | Carry should be updated |
| z_o | output | 1 | New zero value |
| z_we_o | output | 1 | Zero flag should be updated |

## Verification
The embedded checks assume the inputs are settled, two-state values whenever the outputs are evaluated. They also assume that `op_i` may carry any of its sixteen codes, including the unassigned ones. The bench changes inputs only between comparisons and lets them settle for a fixed delay before it samples. It uses every assigned code, several unassigned codes, both position sources, the two extreme positions 0 and 15, and register indexes whose upper bits are nonzero.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        BOP_SET   = 4'd0,
        BOP_CLR   = 4'd1,
        BOP_FLIP  = 4'd2,
        BOP_TSTC  = 4'd3,
        BOP_TSTZ  = 4'd4,
        BOP_TSETC = 4'd5,
        BOP_TSETZ = 4'd6,
        BOP_PUTC  = 4'd7,
        BOP_PUTZ  = 4'd8
    } bitop_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              word_we;
        logic              c;
        logic              c_we;
        logic              z;
        logic              z_we;
    } bitres_t;

    function automatic logic is_pure_test(input logic [OP_W-1:0] op);
        return (op == BOP_TSTC) || (op == BOP_TSTZ);
    endfunction

    function automatic logic is_plain_edit(input logic [OP_W-1:0] op);
        return (op == BOP_SET) || (op == BOP_CLR) || (op == BOP_FLIP);
    endfunction

endpackage

// File: rtl/bit_index_sel.sv
module bit_index_sel
    import bitmanip_pkg::*;
(
    input  logic [IDX_W-1:0]  imm_idx,
    input  logic [WORD_W-1:0] reg_idx,
    input  logic              from_reg,
    output logic [IDX_W-1:0]  idx
);
    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_idx[WORD_W-1:IDX_W];

    assign idx = from_reg ? reg_idx[IDX_W-1:0] : imm_idx;
endmodule

// File: rtl/bit_mask_gen.sv
module bit_mask_gen
    import bitmanip_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] mask
);
    for (genvar g = 0; g < WORD_W; g++) begin : g_dec
        assign mask[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
    import bitmanip_pkg::*;
(
    input  logic [WORD_W-1:0] opnd,
    input  logic [WORD_W-1:0] mask,
    input  logic [OP_W-1:0]   op,
    input  logic              c_in,
    input  logic              z_in,
    output bitres_t           res
);
    logic cur_bit;
    assign cur_bit = |(opnd & mask);

    always_comb begin
        res.word    = opnd;
        res.word_we = 1'b0;
        res.c       = c_in;
        res.c_we    = 1'b0;
        res.z       = z_in;
        res.z_we    = 1'b0;
        case (op)
            BOP_SET: begin
                res.word    = opnd | mask;
                res.word_we = 1'b1;
            end
            BOP_CLR: begin
                res.word    = opnd & ~mask;
                res.word_we = 1'b1;
            end
            BOP_FLIP: begin
                res.word    = opnd ^ mask;
                res.word_we = 1'b1;
            end
            BOP_TSTC: begin
                res.c    = cur_bit;
                res.c_we = 1'b1;
            end
            BOP_TSTZ: begin
                res.z    = ~cur_bit;
                res.z_we = 1'b1;
            end
            BOP_TSETC: begin
                res.c       = cur_bit;
                res.c_we    = 1'b1;
                res.word    = opnd | mask;
                res.word_we = 1'b1;
            end
            BOP_TSETZ: begin
                res.z       = ~cur_bit;
                res.z_we    = 1'b1;
                res.word    = opnd | mask;
                res.word_we = 1'b1;
            end
            BOP_PUTC: begin
                res.word    = c_in ? (opnd | mask) : (opnd & ~mask);
                res.word_we = 1'b1;
            end
            BOP_PUTZ: begin
                res.word    = z_in ? (opnd | mask) : (opnd & ~mask);
                res.word_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bitmanip_pkg::*;
(
    input  logic [15:0] opnd_i,
    input  logic [3:0]  imm_idx_i,
    input  logic [15:0] reg_idx_i,
    input  logic        idx_from_reg_i,
    input  logic [3:0]  op_i,
    input  logic        c_i,
    input  logic        z_i,
    output logic [15:0] word_o,
    output logic        word_we_o,
    output logic        c_o,
    output logic        c_we_o,
    output logic        z_o,
    output logic        z_we_o
);
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] mask;
    bitres_t           res;

    bit_index_sel u_idx (
        .imm_idx  (imm_idx_i),
        .reg_idx  (reg_idx_i),
        .from_reg (idx_from_reg_i),
        .idx      (idx)
    );

    bit_mask_gen u_mask (
        .idx  (idx),
        .mask (mask)
    );

    bitop_core u_core (
        .opnd (opnd_i),
        .mask (mask),
        .op   (op_i),
        .c_in (c_i),
        .z_in (z_i),
        .res  (res)
    );

    assign word_o    = res.word;
    assign word_we_o = res.word_we;
    assign c_o       = res.c;
    assign c_we_o    = res.c_we;
    assign z_o       = res.z;
    assign z_we_o    = res.z_we;

    always_comb begin
        a_r2_mask_onehot: assert ($onehot(mask))
            else $error("decoded position mask is not one-hot");
        if (is_plain_edit(op_i)) begin
            a_r1_single_bit: assert ($countones(word_o ^ opnd_i) <= 1 && !c_we_o && !z_we_o)
                else $error("edit op touched more than one bit or a flag");
        end
        if (is_pure_test(op_i)) begin
            a_r3_test_no_write: assert (!word_we_o && (c_we_o ^ z_we_o))
                else $error("pure test wrote the word or enabled the wrong flags");
        end
        if (op_i == BOP_TSETC || op_i == BOP_TSETZ) begin
            a_r5_tset_forces_one: assert (((word_o & mask) == mask) && word_we_o)
                else $error("test-then-set did not force the bit");
        end
        if (op_i > 4'd8) begin
            a_r9_reserved_quiet: assert (!word_we_o && !c_we_o && !z_we_o && word_o == opnd_i)
                else $error("reserved code had an effect");
        end
        if (!c_we_o) begin
            a_r10_c_hold: assert (c_o == c_i) else $error("carry changed without enable");
        end
        if (!z_we_o) begin
            a_r10_z_hold: assert (z_o == z_i) else $error("zero changed without enable");
        end
    end
endmodule

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;
    logic        clk = 1'b0;
    logic [15:0] opnd_i = '0;
    logic [3:0]  imm_idx_i = '0;
    logic [15:0] reg_idx_i = '0;
    logic        idx_from_reg_i = 1'b0;
    logic [3:0]  op_i = 4'd15;
    logic        c_i = 1'b0;
    logic        z_i = 1'b0;
    logic [15:0] word_o;
    logic        word_we_o, c_o, c_we_o, z_o, z_we_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bitmanip_unit i_bitmanip_unit (
        .opnd_i(opnd_i), .imm_idx_i(imm_idx_i), .reg_idx_i(reg_idx_i),
        .idx_from_reg_i(idx_from_reg_i), .op_i(op_i), .c_i(c_i), .z_i(z_i),
        .word_o(word_o), .word_we_o(word_we_o), .c_o(c_o), .c_we_o(c_we_o),
        .z_o(z_o), .z_we_o(z_we_o)
    );

    // packed view: {word, word_we, c, c_we, z, z_we}
    function automatic logic [20:0] pk(input logic [15:0] w, input logic we,
                                       input logic c, input logic cwe,
                                       input logic z, input logic zwe);
        return {w, we, c, cwe, z, zwe};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic fr,
                         input logic [3:0] imm, input logic [15:0] rg,
                         input logic c, input logic z);
        @(negedge clk);
        op_i = op; opnd_i = a; idx_from_reg_i = fr; imm_idx_i = imm;
        reg_idx_i = rg; c_i = c; z_i = z;
        #1;
    endtask

    task automatic chk(input string req, input logic [20:0] exp);
        logic [20:0] act;
        act = pk(word_o, word_we_o, c_o, c_we_o, z_o, z_we_o);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_idle();
        apply(4'd15, 16'hA5A5, 1'b0, 4'd3, 16'h0, 1'b1, 1'b0);
        chk("R9 idle", pk(16'hA5A5, 0, 1, 0, 0, 0));
    endtask

    task automatic t_edit();
        apply(4'd0, 16'h0000, 1'b0, 4'd15, 16'h0, 1'b0, 1'b1);
        chk("R1 set b15", pk(16'h8000, 1, 0, 0, 1, 0));
        apply(4'd0, 16'h0001, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
        chk("R1 set already set", pk(16'h0001, 1, 1, 0, 0, 0));
        apply(4'd1, 16'hFFFF, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0);
        chk("R1 clear b0", pk(16'hFFFE, 1, 0, 0, 0, 0));
        apply(4'd2, 16'h1234, 1'b0, 4'd7, 16'h0, 1'b1, 1'b1);
        chk("R1 flip b7", pk(16'h12B4, 1, 1, 0, 1, 0));
        apply(4'd2, 16'h12B4, 1'b0, 4'd7, 16'h0, 1'b0, 1'b0);
        chk("R1 flip back", pk(16'h1234, 1, 0, 0, 0, 0));
    endtask

    task automatic t_index_src();
        apply(4'd0, 16'h0000, 1'b1, 4'd2, 16'hFFF9, 1'b0, 1'b0);
        chk("R2 reg low bits", pk(16'h0200, 1, 0, 0, 0, 0));
        apply(4'd0, 16'h0000, 1'b1, 4'd9, 16'h0003, 1'b0, 1'b0);
        chk("R2 reg ignores imm", pk(16'h0008, 1, 0, 0, 0, 0));
        apply(4'd0, 16'h0000, 1'b0, 4'd4, 16'h000B, 1'b0, 1'b0);
        chk("R2 imm ignores reg", pk(16'h0010, 1, 0, 0, 0, 0));
    endtask

    task automatic t_tests();
        apply(4'd3, 16'h0020, 1'b0, 4'd5, 16'h0, 1'b0, 1'b1);
        chk("R3 test C one", pk(16'h0020, 0, 1, 1, 1, 0));
        apply(4'd3, 16'hFFDF, 1'b1, 4'd0, 16'hABC5, 1'b1, 1'b0);
        chk("R3 test C zero", pk(16'hFFDF, 0, 0, 1, 0, 0));
        apply(4'd4, 16'h8000, 1'b0, 4'd15, 16'h0, 1'b1, 1'b1);
        chk("R4 test Z one", pk(16'h8000, 0, 1, 0, 0, 1));
        apply(4'd4, 16'h7FFF, 1'b0, 4'd15, 16'h0, 1'b0, 1'b0);
        chk("R4 test Z zero", pk(16'h7FFF, 0, 0, 0, 1, 1));
    endtask

    task automatic t_tset();
        apply(4'd5, 16'h0000, 1'b0, 4'd9, 16'h0, 1'b1, 1'b0);
        chk("R5 tset C clear bit", pk(16'h0200, 1, 0, 1, 0, 0));
        apply(4'd5, 16'h0200, 1'b0, 4'd9, 16'h0, 1'b0, 1'b1);
        chk("R5 tset C set bit", pk(16'h0200, 1, 1, 1, 1, 0));
        apply(4'd6, 16'h0000, 1'b1, 4'd0, 16'h0010, 1'b0, 1'b0);
        chk("R6 tset Z clear bit", pk(16'h0001, 1, 0, 0, 1, 1));
        apply(4'd6, 16'h0001, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1);
        chk("R6 tset Z set bit", pk(16'h0001, 1, 1, 0, 0, 1));
    endtask

    task automatic t_put();
        apply(4'd7, 16'h0000, 1'b1, 4'd0, 16'h000C, 1'b1, 1'b0);
        chk("R7 store C=1", pk(16'h1000, 1, 1, 0, 0, 0));
        apply(4'd7, 16'hFFFF, 1'b1, 4'd0, 16'h00F0, 1'b0, 1'b1);
        chk("R7 store C=0", pk(16'hFFFE, 1, 0, 0, 1, 0));
        apply(4'd8, 16'h0000, 1'b1, 4'd0, 16'h000F, 1'b0, 1'b1);
        chk("R8 store Z=1", pk(16'h8000, 1, 0, 0, 1, 0));
        apply(4'd8, 16'hFFFF, 1'b1, 4'd0, 16'h0005, 1'b1, 1'b0);
        chk("R8 store Z=0", pk(16'hFFDF, 1, 1, 0, 0, 0));
    endtask

    task automatic t_reserved();
        for (int k = 9; k < 16; k++) begin
            apply(4'(k), 16'h5A3C, 1'b0, 4'(k), 16'h0, 1'b1, 1'b1);
            chk("R9 reserved code", pk(16'h5A3C, 0, 1, 0, 1, 0));
        end
        apply(4'd3, 16'h0000, 1'b0, 4'd1, 16'h0, 1'b0, 1'b1);
        chk("R10 Z held on C test", pk(16'h0000, 0, 0, 1, 1, 0));
        apply(4'd4, 16'h0002, 1'b0, 4'd1, 16'h0, 1'b1, 1'b0);
        chk("R10 C held on Z test", pk(16'h0002, 0, 1, 0, 0, 1));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_edit();
        t_index_src();
        t_tests();
        t_tset();
        t_put();
        t_reserved();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule